// File: doc/BRIEF.md
# Triggered One-Shot Delay Timer

This block is a single 16-bit timer channel that turns an asynchronous trigger edge into a delayed flag edge. While it is idle, the counter holds a programmed start value. A rising edge on the trigger input first passes through a synchroniser. It then starts a count that advances on every clock cycle in which the count-enable input is high. When the count equals the programmed compare value on an enabled cycle, the output flag goes high, the counter reloads its start value and the channel stops until the next trigger edge.

The channel runs only when three configuration values are set: the count-mode field holds the one-shot code, the reinit-on-compare bit is set, and the output-mode field holds the code that clears the flag at initialisation and sets it at compare. Software writes the configuration through a small write-only register port. The delay from trigger to flag is set by the difference between the compare value and the start value. Cycles in which count-enable is low stretch the delay.

Top module: `trig_delay_timer`

## Requirements
- R1: Register writes are synchronous and take effect on the edge where `reg_we` is high. Address 0 is the control word: bits [2:0] hold the count mode, bit 3 holds reinit-on-compare, and bits [7:4] hold the output mode. Address 1 is the start (load) value and address 2 is the compare value.
- R2: The trigger passes through a two-flop synchroniser and a rising-edge detector. If the first clock edge that samples `trig_in` high is edge 0, the count starts on edge 2, with the counter set to the start value.
- R3: While the channel runs, each edge with `cnt_en` high increments the counter, wrapping modulo 2^16. An enabled edge on which the counter equals the compare value is a compare event. With `cnt_en` held high, the flag is first high after edge 3 + (compare − start) mod 2^16.
- R4: An edge with `cnt_en` low leaves the running counter unchanged, so each such edge adds one cycle to the delay.
- R5: On a compare event the counter reloads the start value and stops. The flag then stays high until the next count starts.
- R6: Starting a count (initialisation) clears the flag on that same edge.
- R7: A trigger edge that arrives while a count is running is ignored and does not change the delay.
- R8: If the count mode is not 3'b110, or reinit-on-compare is 0, then from the next edge on the counter is stopped and held at the start value and the flag is 0.
- R9: If the output mode is not 4'b0101, the flag is 0 from the next edge on.
- R10: The reset is synchronous and active high. It clears every register field to zero, stops the counter and drives the flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Primary count enable |
| trig_in | input | 1 | Asynchronous secondary trigger |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| flag_out | output | 1 | Delayed output flag |

## Verification
The bench measures the edge on which the flag rises, so an off-by-one in the synchroniser depth or in the compare test shows up as a wrong edge number. It covers start equal to compare, a large span that wraps near the top of the range, and count-enable pauses; a design that counted paused cycles would fire early. It pulses the trigger again in the middle of a count; a design that restarted would fire late. It also leaves the trigger high while it disarms and re-arms the channel; a design that counted without a fresh edge, or that left a stale flag, would raise the flag when it should not.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

    localparam logic [2:0] MODE_ONESHOT = 3'b110;
    localparam logic [3:0] OUT_CLRINIT_SETCMP = 4'b0101;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_START = 2'd1;
    localparam logic [1:0] ADDR_CMP   = 2'd2;

    typedef struct packed {
        logic [3:0] out_mode;
        logic       reinit;
        logic [2:0] mode;
    } ctrl_t;

endpackage

// File: rtl/tdt_edge_sync.sv
module tdt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN = STAGES + 1;

    typedef struct packed {
        logic [CHAIN-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_in;
        for (int i = 1; i < CHAIN; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rise = s_q.chain[STAGES-1] & ~s_q.chain[STAGES];

endmodule

// File: rtl/tdt_cfg_regs.sv
module tdt_cfg_regs
    import tdt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output ctrl_t        ctrl,
    output logic [W-1:0] start_val,
    output logic [W-1:0] cmp_val
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] start_val;
        logic [W-1:0] cmp_val;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we) begin
            case (addr)
                ADDR_CTRL:  c_d.ctrl      = ctrl_t'(wdata[7:0]);
                ADDR_START: c_d.start_val = wdata;
                ADDR_CMP:   c_d.cmp_val   = wdata;
                default:    c_d = c_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign ctrl      = c_q.ctrl;
    assign start_val = c_q.start_val;
    assign cmp_val   = c_q.cmp_val;

endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         armed,
    input  logic         start,
    input  logic         cnt_en,
    input  logic [W-1:0] start_val,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count,
    output logic         running,
    output logic         init_evt,
    output logic         cmp_evt
);
    typedef struct packed {
        logic [W-1:0] count;
        logic         running;
    } cnt_t;

    cnt_t n_d, n_q;

    always_comb begin
        n_d      = n_q;
        init_evt = 1'b0;
        cmp_evt  = 1'b0;
        if (!armed) begin
            n_d.count   = start_val;
            n_d.running = 1'b0;
        end else if (!n_q.running) begin
            n_d.count = start_val;
            if (start) begin
                n_d.running = 1'b1;
                init_evt    = 1'b1;
            end
        end else if (cnt_en) begin
            if (n_q.count == cmp_val) begin
                n_d.count   = start_val;
                n_d.running = 1'b0;
                cmp_evt     = 1'b1;
            end else begin
                n_d.count = n_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) n_q <= '0;
        else     n_q <= n_d;
    end

    assign count   = n_q.count;
    assign running = n_q.running;

endmodule

// File: rtl/tdt_flag.sv
module tdt_flag
    import tdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       armed,
    input  logic [3:0] out_mode,
    input  logic       init_evt,
    input  logic       cmp_evt,
    output logic       flag
);
    typedef struct packed {
        logic flag;
    } flg_t;

    flg_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!armed || out_mode != OUT_CLRINIT_SETCMP) f_d.flag = 1'b0;
        else if (init_evt)                            f_d.flag = 1'b0;
        else if (cmp_evt)                             f_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign flag = f_q.flag;

endmodule

// File: rtl/trig_delay_timer.sv
module trig_delay_timer
    import tdt_pkg::*;
#(
    parameter int W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         trig_in,
    input  logic         reg_we,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic         flag_out
);
    ctrl_t        ctrl;
    logic [W-1:0] start_val;
    logic [W-1:0] cmp_val;
    logic [W-1:0] count;
    logic [3:0]   out_mode;
    logic         armed;
    logic         start_pulse;
    logic         running;
    logic         init_evt;
    logic         cmp_evt;

    tdt_cfg_regs #(.W(W)) u_cfg (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .ctrl(ctrl), .start_val(start_val), .cmp_val(cmp_val)
    );

    tdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(trig_in), .rise(start_pulse)
    );

    assign armed    = (ctrl.mode == MODE_ONESHOT) && ctrl.reinit;
    assign out_mode = ctrl.out_mode;

    tdt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .armed(armed), .start(start_pulse), .cnt_en(cnt_en),
        .start_val(start_val), .cmp_val(cmp_val), .count(count),
        .running(running), .init_evt(init_evt), .cmp_evt(cmp_evt)
    );

    tdt_flag u_flag (
        .clk(clk), .rst(rst), .armed(armed), .out_mode(out_mode),
        .init_evt(init_evt), .cmp_evt(cmp_evt), .flag(flag_out)
    );

endmodule

// File: rtl/tdt_chk.sv
module tdt_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic         armed,
    input logic         start,
    input logic         running,
    input logic [W-1:0] count,
    input logic [W-1:0] cmp_val,
    input logic [3:0]   out_mode,
    input logic         flag
);
    // R4
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        running && armed && !cnt_en |=> $stable(count) && running);

    // R5
    cmp_fire_chk: assert property (@(posedge clk) disable iff (rst)
        running && armed && cnt_en && (count == cmp_val) && (out_mode == 4'b0101)
        |=> flag && !running);

    // R6
    init_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> !flag);

    // R7
    retrig_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        running && armed && start && !(cnt_en && (count == cmp_val)) |=> running);

    // R8
    disarm_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !flag && !running);

    // R9
    bad_outmode_chk: assert property (@(posedge clk) disable iff (rst)
        out_mode != 4'b0101 |=> !flag);

endmodule

bind trig_delay_timer tdt_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .armed(armed), .start(start_pulse),
    .running(running), .count(count), .cmp_val(cmp_val), .out_mode(out_mode),
    .flag(flag_out)
);

// File: tb/test_trig_delay_timer.sv
`timescale 1ns/1ps
module test_trig_delay_timer;
    localparam int W = 16;
    localparam logic [15:0] NONE = 16'hFFFF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b1;
    logic         trig_in = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic         flag_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trig_delay_timer #(.W(W)) i_trig_delay_timer (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .trig_in(trig_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .flag_out(flag_out)
    );

    typedef struct packed {
        logic [15:0] ld;
        logic [15:0] cp;
        logic [3:0]  om;
        logic [15:0] exp_edge;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'd0,      16'd4,      4'b0101, 16'd7},
        '{16'd10,     16'd10,     4'b0101, 16'd3},
        '{16'd100,    16'd131,    4'b0101, 16'd34},
        '{16'hFFF0,   16'hFFFE,   4'b0101, 16'd17},
        '{16'd5,      16'd9,      4'b0011, NONE}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rest_low();
        @(negedge clk);
        trig_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Raise trigger, then watch edges 0..limit-1; returns the first edge >= 2
    // with the flag high (-1 if none) and the flag level seen after edge 2.
    task automatic measure(input int limit, input int pause_from, input int pause_len,
                           input bit retrig, output int first, output bit flag_at2);
        first = -1;
        flag_at2 = 1'b0;
        trig_in = 1'b1;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 2) flag_at2 = flag_out;
            if (flag_out && first < 0 && i >= 2) first = i;
            cnt_en = !(i >= pause_from && i < pause_from + pause_len);
            if (retrig && i == 2) trig_in = 1'b0;
            if (retrig && i == 4) trig_in = 1'b1;
        end
        cnt_en = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int first;
        bit f2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(flag_out == 1'b0, "R10", flag_out, 0);

        // R8, R10: reset config (mode 000) never counts
        measure(40, 100, 0, 0, first, f2);
        check(first == -1, "R8 reset mode idle", first, -1);
        rest_low();

        // Table walk: R1, R2, R3, R5, R6, R9
        foreach (VECS[k]) begin
            wr(2'd1, VECS[k].ld);
            wr(2'd2, VECS[k].cp);
            wr(2'd0, {8'h00, VECS[k].om, 1'b1, 3'b110});
            rest_low();
            measure(60, 100, 0, 0, first, f2);
            if (VECS[k].exp_edge == NONE) begin
                check(first == -1, "R9 flag stays 0", first, -1);
            end else begin
                check(first == int'(VECS[k].exp_edge), "R3 flag edge", first, int'(VECS[k].exp_edge));
                check(f2 == 1'b0, "R6 flag cleared at start", f2, 0);
                check(flag_out == 1'b1, "R5 flag held after compare", flag_out, 1);
            end
            rest_low();
        end

        // R4: three paused edges delay start 0 / compare 4 to edge 10
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h005E);
        rest_low();
        measure(40, 2, 3, 0, first, f2);
        check(first == 10, "R4 pause stretches delay", first, 10);
        rest_low();

        // R7: retrigger during count ignored, compare 10 -> edge 13
        wr(2'd2, 16'd10);
        rest_low();
        measure(40, 100, 0, 1, first, f2);
        check(first == 13, "R7 retrigger ignored", first, 13);
        check(f2 == 1'b0, "R6 flag cleared on restart", f2, 0);
        rest_low();

        // R8: disarm mid-count, re-arm with trigger held high: no count
        wr(2'd2, 16'd20);
        @(negedge clk);
        trig_in = 1'b1;
        repeat (6) @(negedge clk);
        wr(2'd0, 16'h0000);
        check(flag_out == 1'b0, "R8 disarm clears flag", flag_out, 0);
        wr(2'd0, 16'h005E);
        first = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (flag_out && first < 0) first = i;
        end
        check(first == -1, "R8 no count without new edge", first, -1);
        rest_low();

        // R8: reinit bit clear blocks one-shot
        wr(2'd2, 16'd3);
        wr(2'd0, 16'h0056);
        rest_low();
        measure(30, 100, 0, 0, first, f2);
        check(first == -1, "R8 reinit bit clear", first, -1);
        rest_low();

        // R1: load register updates delay (start 1, compare 4 -> edge 6)
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h005E);
        rest_low();
        measure(30, 100, 0, 0, first, f2);
        check(first == 6, "R1 register write effect", first, 6);
        check(flag_out == 1'b1, "R5 flag held", flag_out, 1);

        // R10: reset mid-way clears flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(flag_out == 1'b0, "R10 reset clears flag", flag_out, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule